// File: doc/BRIEF.md
# Sleep Wake-Up Interrupt Sequencer

This block owns the instruction-cycle timing of a small processor core around its low-power state. It divides the raw oscillator into a four-phase instruction cycle and advances the program counter once per cycle. It parks the core when a sleep request arrives, and it restarts the core when an external interrupt edge is latched. On restart it optionally waits for the crystal oscillator to settle. It then executes the instruction that was prefetched before sleeping. After that it either jumps to the interrupt vector through a dummy cycle or carries on in line.

The controller has five named states. ST_RUN is normal execution. ST_SLEEP is the parked state, with the cycle clock stopped and the PC held. ST_OST is the oscillator start-up wait. ST_RESUME is the cycle that executes the held prefetch. ST_DUMMY is the vectoring bubble.

The transitions are as follows. RUN→SLEEP happens on a sleep request at the last phase. SLEEP→OST happens on a latched flag in crystal mode. SLEEP→RESUME happens on a latched flag in RC mode. OST→RESUME happens when the start-up count expires. RESUME→DUMMY happens at the end of the cycle with the enable set. RESUME→RUN happens at the end of the cycle with the enable clear. DUMMY→RUN happens at the end of the bubble. Reset puts the block in ST_RUN with PC 0, phase Q1, the flag clear and the enable clear.

Top module: `sleep_wake_seq`

## Requirements
- R1: While the core is clocked (ST_RUN, ST_RESUME, ST_DUMMY), `q_phase` is one-hot and rotates bit0→bit1→bit2→bit3→bit0 on successive clocks. `cyc_clk` is 1 during bit0 and bit1 and 0 otherwise. While parked or waiting, `q_phase` is 0 and `cyc_clk` is 0.
- R2: After reset `pc` is 0 and `q_phase` is 4'b0001. In ST_RUN, `pc` increments by one on the clock that ends phase bit3.
- R3: A rising edge on `ext_int_pin` sets `int_flag` on the following clock, whether or not the core is asleep. `int_flag_clr` clears it. A simultaneous edge wins over the clear.
- R4: If `sleep_req` is high on the clock ending bit3 in ST_RUN and no enabled interrupt is pending, the block enters ST_SLEEP. `asleep` goes to 1, `exec_kind` reads 2'b10 (halt), and `pc` is advanced once and then held.
- R5: A sleep request made while `int_flag` and `gie` are both 1 is a no-op. The core stays in ST_RUN and keeps counting.
- R6: In crystal mode (`osc_rc`=0), the first clock that sees `int_flag` high in ST_SLEEP starts a wait of exactly OST_LEN oscillator clocks before phase bit0 reappears. The start-up counter is reset on each entry.
- R7: In RC mode (`osc_rc`=1), phase bit0 reappears on the clock right after ST_SLEEP sees `int_flag` high.
- R8: The first cycle after waking executes the held prefetch (`exec_kind`=2'b00) with `pc` unchanged from the sleep value.
- R9: With `gie`=1 at the end of the resume cycle, the next cycle is a dummy (`exec_kind`=2'b01) with `pc`=VEC_ADDR (default 4). The cycle after that fetches VEC_ADDR+1. `ret_addr` captures the sleep `pc`, and `gie` is cleared.
- R10: With `gie`=0 at the end of the resume cycle, the core returns to ST_RUN with `pc` incremented by one. `gie` and `ret_addr` are unchanged.
- R11: `gie_wr` loads `gie` from `gie_wr_val` on the next clock, except on the clock that vectors, where the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_int_pin | input | 1 | External interrupt pin, rising-edge sensitive |
| int_flag_clr | input | 1 | Clears the interrupt flag |
| gie_wr | input | 1 | Write strobe for the global interrupt enable |
| gie_wr_val | input | 1 | Value written to the global interrupt enable |
| osc_rc | input | 1 | 1 = RC oscillator (no start-up wait), 0 = crystal |
| sleep_req | input | 1 | The executing instruction is a sleep |
| q_phase | output | 4 | One-hot instruction phase, bit0 = first phase |
| cyc_clk | output | 1 | Instruction-cycle clock |
| pc | output | PC_W | Current fetch address |
| exec_kind | output | 2 | 00 normal, 01 dummy, 10 halted |
| asleep | output | 1 | Core parked or waiting for the oscillator |
| int_flag | output | 1 | Latched external interrupt flag |
| gie | output | 1 | Global interrupt enable |
| ret_addr | output | PC_W | Return address saved on vectoring |

## Verification
Wake-up is tried in four combinations: crystal versus RC start-up, crossed with enable set versus enable clear. Separate timing checks show whether a start-up wait was inserted and whether its length is exact. The fetch sequence after waking separates vectoring (dummy, vector, vector+1, return address saved, enable dropped) from in-line continuation. Sleep requests made with an enabled flag already pending show that the no-op path is taken. A pin edge arriving together with a clear shows which of the two has priority.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_OST    = 3'd2,
        ST_RESUME = 3'd3,
        ST_DUMMY  = 3'd4
    } sws_state_e;

    typedef enum logic [1:0] {
        EX_NORMAL = 2'b00,
        EX_DUMMY  = 2'b01,
        EX_HALT   = 2'b10
    } sws_exec_e;

    function automatic logic state_clocked(input sws_state_e s);
        return (s == ST_RUN) || (s == ST_RESUME) || (s == ST_DUMMY);
    endfunction

endpackage

// File: rtl/sws_phase_gen.sv
module sws_phase_gen #(
    parameter int unsigned NPH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    output logic [NPH-1:0] q_phase,
    output logic           cyc_clk,
    output logic           phase_last
);
    localparam int unsigned PH_W = (NPH > 1) ? $clog2(NPH) : 1;
    localparam logic [PH_W-1:0] LAST_IDX = PH_W'(NPH - 1);
    localparam logic [PH_W-1:0] HALF_IDX = PH_W'(NPH / 2);

    logic [PH_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!run) begin
            idx <= '0;
        end else if (idx == LAST_IDX) begin
            idx <= '0;
        end else begin
            idx <= idx + PH_W'(1);
        end
    end

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        assign q_phase[i] = run && (idx == PH_W'(i));
    end

    assign cyc_clk    = run && (idx < HALF_IDX);
    assign phase_last = run && (idx == LAST_IDX);

    p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_phase));

    for (genvar j = 0; j < NPH - 1; j++) begin : g_seq_chk
        p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
            q_phase[j] |=> q_phase[j+1]);
    end

endmodule

// File: rtl/sws_int_edge.sv
module sws_int_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic flag
);
    logic pin_q;
    logic rise;

    assign rise = pin && !pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pin_q <= pin;
            if (rise) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin && !pin_q) |=> flag);

    p_flag_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(pin && !pin_q)) |=> !flag);

endmodule

// File: rtl/sws_ost_timer.sv
module sws_ost_timer #(
    parameter int unsigned OST_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int unsigned CNT_W = (OST_LEN > 1) ? $clog2(OST_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OST_LEN - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign done = en && (cnt == CNT_TOP);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_TOP);

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !done) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

endmodule

// File: rtl/sws_ctrl.sv
module sws_ctrl
    import sws_pkg::*;
#(
    parameter int unsigned PC_W     = 13,
    parameter int unsigned VEC_ADDR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phase_last,
    input  logic            int_flag,
    input  logic            osc_rc,
    input  logic            sleep_req,
    input  logic            ost_done,
    input  logic            gie_wr,
    input  logic            gie_wr_val,
    output sws_state_e      state,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] ret_addr,
    output logic            gie
);
    localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);

    sws_state_e nxt;
    logic       pend_enabled;
    logic       vectoring;
    logic       cycle_end;

    assign pend_enabled = int_flag && gie;
    assign cycle_end    = state_clocked(state) && phase_last;
    assign vectoring    = (state == ST_RESUME) && phase_last && gie;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (phase_last && sleep_req && !pend_enabled) begin
                    nxt = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (int_flag) begin
                    nxt = osc_rc ? ST_RESUME : ST_OST;
                end
            end
            ST_OST: begin
                if (ost_done) begin
                    nxt = ST_RESUME;
                end
            end
            ST_RESUME: begin
                if (phase_last) begin
                    nxt = gie ? ST_DUMMY : ST_RUN;
                end
            end
            ST_DUMMY: begin
                if (phase_last) begin
                    nxt = ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // Program counter, return register and enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= '0;
            ret_addr <= '0;
            gie      <= 1'b0;
        end else begin
            if (cycle_end) begin
                pc <= vectoring ? VEC_PC : pc + PC_W'(1);
            end
            if (vectoring) begin
                ret_addr <= pc;
                gie      <= 1'b0;
            end else if (gie_wr) begin
                gie <= gie_wr_val;
            end
        end
    end

    p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP) || (state == ST_OST)) |=> $stable(pc));

    p_sleep_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && phase_last && sleep_req && int_flag && gie)
        |=> (state == ST_RUN));

    p_rc_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP) && int_flag && osc_rc) |=> (state == ST_RESUME));

    p_dummy_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY) |-> ((pc == VEC_PC) && !gie));

    p_inline_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RESUME) && phase_last && !gie)
        |=> ((state == ST_RUN) && (pc == $past(pc) + PC_W'(1))));

    p_gie_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_wr && !((state == ST_RESUME) && phase_last && gie))
        |=> (gie == $past(gie_wr_val)));

endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
    import sws_pkg::*;
#(
    parameter int unsigned PC_W     = 13,
    parameter int unsigned OST_LEN  = 1024,
    parameter int unsigned VEC_ADDR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_int_pin,
    input  logic            int_flag_clr,
    input  logic            gie_wr,
    input  logic            gie_wr_val,
    input  logic            osc_rc,
    input  logic            sleep_req,
    output logic [3:0]      q_phase,
    output logic            cyc_clk,
    output logic [PC_W-1:0] pc,
    output logic [1:0]      exec_kind,
    output logic            asleep,
    output logic            int_flag,
    output logic            gie,
    output logic [PC_W-1:0] ret_addr
);
    localparam int unsigned NPH = 4;

    sws_state_e state;
    sws_exec_e  ex;
    logic       run;
    logic       phase_last;
    logic       ost_en;
    logic       ost_done;

    assign run    = state_clocked(state);
    assign ost_en = (state == ST_OST);
    assign asleep = (state == ST_SLEEP) || (state == ST_OST);

    always_comb begin
        unique case (state)
            ST_RUN, ST_RESUME: ex = EX_NORMAL;
            ST_DUMMY:          ex = EX_DUMMY;
            default:           ex = EX_HALT;
        endcase
    end
    assign exec_kind = ex;

    sws_phase_gen #(.NPH(NPH)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .q_phase    (q_phase),
        .cyc_clk    (cyc_clk),
        .phase_last (phase_last)
    );

    sws_int_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_int_pin),
        .clr   (int_flag_clr),
        .flag  (int_flag)
    );

    sws_ost_timer #(.OST_LEN(OST_LEN)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ost_en),
        .done  (ost_done)
    );

    sws_ctrl #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_last (phase_last),
        .int_flag   (int_flag),
        .osc_rc     (osc_rc),
        .sleep_req  (sleep_req),
        .ost_done   (ost_done),
        .gie_wr     (gie_wr),
        .gie_wr_val (gie_wr_val),
        .state      (state),
        .pc         (pc),
        .ret_addr   (ret_addr),
        .gie        (gie)
    );

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> ((q_phase == 4'b0000) && !cyc_clk && (exec_kind == 2'b10)));

endmodule

// File: tb/sleep_wake_seq_test.sv
module sleep_wake_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 13;
    localparam int OST_LEN    = 1024;
    localparam int VEC_ADDR   = 4;
    localparam int PC_MASK    = (1 << PC_W) - 1;
    localparam int WATCHDOG   = 100000;

    // model state codes
    localparam int M_RUN = 0, M_SLEEP = 1, M_OST = 2, M_RESUME = 3, M_DUMMY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_int_pin = 1'b0;
    logic int_flag_clr = 1'b0;
    logic gie_wr = 1'b0;
    logic gie_wr_val = 1'b0;
    logic osc_rc = 1'b0;
    logic sleep_req = 1'b0;

    logic [3:0]      q_phase;
    logic            cyc_clk;
    logic [PC_W-1:0] pc;
    logic [1:0]      exec_kind;
    logic            asleep;
    logic            int_flag;
    logic            gie;
    logic [PC_W-1:0] ret_addr;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference model
    int m_state, m_ph, m_pc, m_ret, m_cnt;
    bit m_flag, m_prev, m_gie;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_wake_seq #(.PC_W(PC_W), .OST_LEN(OST_LEN), .VEC_ADDR(VEC_ADDR)) uut (
        .clk(clk), .rst_n(rst_n), .ext_int_pin(ext_int_pin),
        .int_flag_clr(int_flag_clr), .gie_wr(gie_wr), .gie_wr_val(gie_wr_val),
        .osc_rc(osc_rc), .sleep_req(sleep_req), .q_phase(q_phase),
        .cyc_clk(cyc_clk), .pc(pc), .exec_kind(exec_kind), .asleep(asleep),
        .int_flag(int_flag), .gie(gie), .ret_addr(ret_addr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = M_RUN; m_ph = 0; m_pc = 0; m_ret = 0; m_cnt = 0;
            m_flag = 0; m_prev = 0; m_gie = 0;
        end else begin
            bit rise, vec, f_n, g_n;
            int s_n, ph_n, pc_n, c_n;
            rise = ext_int_pin && !m_prev;
            vec  = (m_state == M_RESUME) && (m_ph == 3) && m_gie;
            f_n  = rise ? 1'b1 : (int_flag_clr ? 1'b0 : m_flag);
            g_n  = vec ? 1'b0 : (gie_wr ? gie_wr_val : m_gie);
            s_n = m_state; pc_n = m_pc; c_n = 0;
            ph_n = (m_state == M_RUN || m_state == M_RESUME || m_state == M_DUMMY)
                   ? (m_ph + 1) % 4 : 0;
            case (m_state)
                M_RUN: if (m_ph == 3) begin
                    pc_n = (m_pc + 1) & PC_MASK;
                    if (sleep_req && !(m_flag && m_gie)) s_n = M_SLEEP;
                end
                M_SLEEP: if (m_flag) s_n = osc_rc ? M_RESUME : M_OST;
                M_OST: begin
                    if (m_cnt == OST_LEN - 1) s_n = M_RESUME;
                    else c_n = m_cnt + 1;
                end
                M_RESUME: if (m_ph == 3) begin
                    if (m_gie) begin
                        s_n = M_DUMMY; m_ret = m_pc; pc_n = VEC_ADDR;
                    end else begin
                        s_n = M_RUN; pc_n = (m_pc + 1) & PC_MASK;
                    end
                end
                M_DUMMY: if (m_ph == 3) begin
                    s_n = M_RUN; pc_n = (m_pc + 1) & PC_MASK;
                end
                default: s_n = M_RUN;
            endcase
            m_state = s_n; m_ph = ph_n; m_pc = pc_n; m_cnt = c_n;
            m_flag = f_n; m_gie = g_n; m_prev = ext_int_pin;
        end
    end

    task automatic fail_line(input string req, input string what, input int act, input int exp_v);
        miscompares++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp_v);
        vectors++;
        if (act != exp_v) fail_line(req, what, act, exp_v);
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit clk_on;
            int e_ph, e_ex;
            clk_on = (m_state == M_RUN || m_state == M_RESUME || m_state == M_DUMMY);
            e_ph = clk_on ? (1 << m_ph) : 0;
            e_ex = (m_state == M_DUMMY) ? 1 : (clk_on ? 0 : 2);
            vectors++;
            if (q_phase != e_ph)            fail_line("R1", "q_phase", q_phase, e_ph);
            if (cyc_clk != (clk_on && m_ph < 2)) fail_line("R1", "cyc_clk", cyc_clk, clk_on && m_ph < 2);
            if (pc != m_pc)                 fail_line("R2", "pc", pc, m_pc);
            if (int_flag != m_flag)         fail_line("R3", "int_flag", int_flag, m_flag);
            if (asleep != !clk_on)          fail_line("R4", "asleep", asleep, !clk_on);
            if (exec_kind != e_ex)          fail_line("R8", "exec_kind", exec_kind, e_ex);
            if (gie != m_gie)               fail_line("R11", "gie", gie, m_gie);
            if (ret_addr != m_ret)          fail_line("R9", "ret_addr", ret_addr, m_ret);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pin();
        ext_int_pin = 1'b1; step(1); ext_int_pin = 1'b0;
    endtask

    task automatic clear_flag();
        int_flag_clr = 1'b1; step(1); int_flag_clr = 1'b0;
    endtask

    task automatic write_gie(input bit v);
        gie_wr = 1'b1; gie_wr_val = v; step(1); gie_wr = 1'b0;
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        for (int i = 0; i < 8 && !asleep; i++) step(1);
        sleep_req = 1'b0;
    endtask

    // returns negedges from flag first seen to phase bit0 reappearing
    task automatic wake_time(output int n);
        n = 0;
        pulse_pin();
        for (int i = 0; i < 4 && !int_flag; i++) step(1);
        for (int i = 0; i < 3000 && q_phase != 4'b0001; i++) begin
            step(1); n++;
        end
    endtask

    initial begin
        int t;
        int held;
        step(3);
        rst_n = 1'b1;
        check("R2", "reset pc", pc, 0);
        check("R2", "reset q_phase", q_phase, 1);
        check("R3", "reset int_flag", int_flag, 0);
        step(20);
        check("R2", "pc after 20 clocks", pc, 5);

        // crystal mode, enable clear: start-up wait then in-line continuation
        osc_rc = 1'b0;
        go_sleep();
        check("R4", "asleep after request", asleep, 1);
        held = pc;
        step(5);
        check("R4", "pc held asleep", pc, held);
        wake_time(t);
        check("R6", "crystal start-up clocks", t, OST_LEN + 1);
        check("R8", "resume pc", pc, held);
        check("R8", "resume exec_kind", exec_kind, 0);
        step(4);
        check("R10", "in-line pc", pc, (held + 1) & PC_MASK);
        check("R10", "in-line exec_kind", exec_kind, 0);
        check("R10", "gie untouched", gie, 0);
        clear_flag();
        step(6);

        // R5: enabled pending flag makes sleep a no-op
        write_gie(1'b1);
        pulse_pin();
        step(2);
        sleep_req = 1'b1;
        step(8);
        check("R5", "sleep no-op asleep", asleep, 0);
        sleep_req = 1'b0;
        clear_flag();
        step(3);

        // R3: edge and clear together; edge wins
        ext_int_pin = 1'b1; int_flag_clr = 1'b1; step(1);
        ext_int_pin = 1'b0; int_flag_clr = 1'b0; step(1);
        check("R3", "edge beats clear", int_flag, 1);
        clear_flag();
        check("R3", "flag cleared", int_flag, 0);

        // RC mode, enable set: immediate resume then vectoring
        osc_rc = 1'b1;
        go_sleep();
        held = pc;
        wake_time(t);
        check("R7", "rc start-up clocks", t, 1);
        check("R8", "rc resume pc", pc, held);
        step(4);
        check("R9", "dummy exec_kind", exec_kind, 1);
        check("R9", "dummy pc", pc, VEC_ADDR);
        check("R9", "gie cleared", gie, 0);
        check("R9", "ret_addr", ret_addr, held);
        step(4);
        check("R9", "vector+1 pc", pc, VEC_ADDR + 1);
        check("R9", "after dummy exec_kind", exec_kind, 0);
        clear_flag();

        // crystal mode, enable set
        osc_rc = 1'b0;
        write_gie(1'b1);
        check("R11", "gie written", gie, 1);
        step(2);
        go_sleep();
        held = pc;
        wake_time(t);
        check("R6", "crystal start-up again", t, OST_LEN + 1);
        step(4);
        check("R9", "crystal dummy pc", pc, VEC_ADDR);
        check("R9", "crystal ret_addr", ret_addr, held);
        step(12);
        finish_run();
    end
endmodule